// File: doc/BRIEF.md
# Multi-Tap Circular Delay Line

This block delays a sample stream and presents several delayed copies of it at the same time. Each copy, or tap, has its own delay fixed when the block is built. The block accepts one sample per clock while its valid strobe is high. Samples go into a ring of storage whose depth is a power of two. A write pointer wraps by masking, and the stored data is never shifted or rotated. Each tap reads at the write pointer minus its delay, masked to the ring size. Every tap with a non-zero delay has its own simple dual-port copy of the ring. All copies receive the same writes, so all taps can read in the same cycle. A tap with zero delay skips the storage and registers the input directly.

All tap outputs have the same latency: they update on the clock edge after a sample is accepted. A tap raises its valid flag only after enough samples have been written since reset to fill its delay window. Contents from before the reset are never marked valid. When the input strobe is low, the pointer stays put, the tap data holds, and the tap valid flags are low. The depth and the tap delays are parameters. Elaboration stops if the depth is not a power of two or if any delay does not fit the ring.

Top module: `tap_delay_line`

## Requirements
- R1: The write pointer advances by one for each accepted sample (in_valid high at a rising edge) and wraps from DEPTH-1 to 0. Taps keep returning correct data across the wrap, including when more than DEPTH samples are streamed.
- R2: For tap i with delay D greater than 0 (tap_data bits [i*DATA_W +: DATA_W]), the edge that accepts sample k loads tap_data with sample k-D.
- R3: A tap with delay 0 loads tap_data with the sample accepted at the same edge.
- R4: With in_valid held high, a new sample is accepted every clock and all taps update on the same edge.
- R5: tap_valid bit i goes high on an accepting edge only when at least D+1 samples have been accepted since reset, counting the current one. Otherwise it is low.
- R6: An edge with in_valid low does not move the write pointer and leaves every tap_data unchanged. It drives every tap_valid bit low.
- R7: A synchronous active-high reset clears the write pointer and the fill count but not the stored samples. After the reset, each tap stays invalid until D+1 new samples have been accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe; a sample is accepted on each edge where this is high |
| in_data | input | DATA_W | Input sample |
| tap_valid | output | TAP_CNT | Per-tap valid flag, bit i for tap i |
| tap_data | output | TAP_CNT*DATA_W | Tap outputs, tap i at bits [i*DATA_W +: DATA_W] |

## Verification
Every tap result, both data and valid, is due on the first rising edge after the edge that samples in_valid and in_data. This holds for the memory taps and the zero-delay tap alike, because there is exactly one register between input and output. The bench drives each stimulus at a falling edge, waits through one rising edge, and compares all taps at the next falling edge against a history of accepted samples. During idle cycles it compares each tap with the last value it was known to hold. After a reset it counts the newly accepted samples again to predict when each tap becomes valid.

// File: rtl/dl_pkg.sv
package dl_pkg;
   // Width of one tap offset field in the packed offset parameter
   localparam int OFF_W = 32;

   function automatic bit is_pow2(input int value);
      return (value >= 2) && ((value & (value - 1)) == 0);
   endfunction
endpackage

// File: rtl/dl_wr_ctrl.sv
module dl_wr_ctrl #(
   parameter int AW = 9
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_valid,
   output logic [AW-1:0] wptr,
   output logic [AW-1:0] fill
);
   localparam logic [AW-1:0] MASK     = {AW{1'b1}};
   localparam logic [AW-1:0] FILL_MAX = {AW{1'b1}};

   always_ff @(posedge clk) begin
      if (rst) begin
         wptr <= '0;
         fill <= '0;
      end else if (in_valid) begin
         wptr <= (wptr + AW'(1)) & MASK;
         if (fill != FILL_MAX) fill <= fill + AW'(1);
      end
   end

   a_r1_ptr_step: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> wptr == AW'($past(wptr) + AW'(1)));

   a_r6_ptr_hold: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(wptr) && $stable(fill));
endmodule

// File: rtl/dl_sdp_ram.sv
module dl_sdp_ram #(
   parameter int DW = 16,
   parameter int AW = 9
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/dl_tap_mem.sv
module dl_tap_mem #(
   parameter int DW = 16,
   parameter int AW = 9
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_valid,
   input  logic [DW-1:0] in_data,
   input  logic [AW-1:0] waddr,
   input  logic [AW-1:0] raddr,
   input  logic          armed,
   output logic          tap_valid,
   output logic [DW-1:0] tap_data
);
   dl_sdp_ram #(.DW(DW), .AW(AW)) i_ram (
      .clk   (clk),
      .we    (in_valid),
      .waddr (waddr),
      .wdata (in_data),
      .re    (in_valid),
      .raddr (raddr),
      .rdata (tap_data)
   );

   always_ff @(posedge clk) begin
      if (rst) tap_valid <= 1'b0;
      else     tap_valid <= in_valid & armed;
   end

   a_r6_data_hold: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(tap_data));

   a_r2_no_same_addr: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> raddr != waddr);
endmodule

// File: rtl/dl_tap_bypass.sv
module dl_tap_bypass #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_valid,
   input  logic [DW-1:0] in_data,
   output logic          tap_valid,
   output logic [DW-1:0] tap_data
);
   always_ff @(posedge clk) begin
      if (in_valid) tap_data <= in_data;
   end

   always_ff @(posedge clk) begin
      if (rst) tap_valid <= 1'b0;
      else     tap_valid <= in_valid;
   end
endmodule

// File: rtl/tap_delay_line.sv
module tap_delay_line #(
   parameter int DATA_W  = 16,
   parameter int DEPTH   = 512,
   parameter int TAP_CNT = 4,
   parameter logic [TAP_CNT*dl_pkg::OFF_W-1:0] TAP_OFFS =
      {32'd335, 32'd43, 32'd22, 32'd0}
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      in_valid,
   input  logic [DATA_W-1:0]         in_data,
   output logic [TAP_CNT-1:0]        tap_valid,
   output logic [TAP_CNT*DATA_W-1:0] tap_data
);
   localparam int AW    = $clog2(DEPTH);
   localparam int OFF_W = dl_pkg::OFF_W;

   if (!dl_pkg::is_pow2(DEPTH)) begin : g_bad_depth
      $error("tap_delay_line: DEPTH must be a power of two, at least 2");
   end
   if (DATA_W < 1 || TAP_CNT < 1) begin : g_bad_size
      $error("tap_delay_line: DATA_W and TAP_CNT must be positive");
   end

   logic [AW-1:0] wptr;
   logic [AW-1:0] fill;

   dl_wr_ctrl #(.AW(AW)) i_wr_ctrl (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .wptr     (wptr),
      .fill     (fill)
   );

   for (genvar gi = 0; gi < TAP_CNT; gi++) begin : g_tap
      localparam int OFF = int'(TAP_OFFS[gi*OFF_W +: OFF_W]);

      if (OFF >= DEPTH) begin : g_bad_off
         $error("tap_delay_line: tap offset does not fit the ring");
      end

      if (OFF == 0) begin : g_bypass
         dl_tap_bypass #(.DW(DATA_W)) i_tap (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (in_valid),
            .in_data   (in_data),
            .tap_valid (tap_valid[gi]),
            .tap_data  (tap_data[gi*DATA_W +: DATA_W])
         );

         a_r3_bypass_data: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> tap_data[gi*DATA_W +: DATA_W] == $past(in_data));
      end else begin : g_mem
         localparam logic [AW-1:0] MASK  = {AW{1'b1}};
         localparam logic [AW-1:0] OFF_A = AW'(OFF);

         logic [AW-1:0] raddr;
         logic          armed;

         assign raddr = (wptr - OFF_A) & MASK;
         assign armed = (fill >= OFF_A);

         dl_tap_mem #(.DW(DATA_W), .AW(AW)) i_tap (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (in_valid),
            .in_data   (in_data),
            .waddr     (wptr),
            .raddr     (raddr),
            .armed     (armed),
            .tap_valid (tap_valid[gi]),
            .tap_data  (tap_data[gi*DATA_W +: DATA_W])
         );
      end
   end

   a_r6_idle_novld: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> tap_valid == '0);

   a_r7_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> tap_valid == '0);
endmodule

// File: tb/test_tap_delay_line.sv
module test_tap_delay_line;
   localparam int CLK_PERIOD = 10;
   localparam int DW    = 16;
   localparam int DEPTH = 512;
   localparam int NT    = 4;
   localparam int OFFS [NT] = '{0, 22, 43, 335};
   localparam int HMAX  = 8192;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              in_valid = 1'b0;
   logic [DW-1:0]     in_data = '0;
   logic [NT-1:0]     tap_valid;
   logic [NT*DW-1:0]  tap_data;

   int n_chk  = 0;
   int n_fail = 0;

   logic [DW-1:0] hist [HMAX];
   int            n_acc = 0;
   logic [DW-1:0] last_exp [NT];
   bit            known [NT];

   always #(CLK_PERIOD/2) clk = ~clk;

   tap_delay_line #(
      .DATA_W(DW), .DEPTH(DEPTH), .TAP_CNT(NT),
      .TAP_OFFS({32'd335, 32'd43, 32'd22, 32'd0})
   ) i_tap_delay_line (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .tap_valid(tap_valid), .tap_data(tap_data)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Drive one cycle, then compare every tap one edge later at the falling edge.
   task automatic step(input bit v, input logic [DW-1:0] d, input string tag);
      in_valid = v;
      in_data  = d;
      @(posedge clk);
      @(negedge clk);
      if (v) begin
         hist[n_acc] = d;
         n_acc++;
      end
      for (int i = 0; i < NT; i++) begin
         bit e;
         e = v && (n_acc >= OFFS[i] + 1);
         check($sformatf("%s/R5 tap%0d valid", tag, i), 32'(tap_valid[i]), 32'(e));
         if (v) begin
            if (e) begin
               check($sformatf("%s/%s tap%0d data", tag, (OFFS[i] == 0) ? "R3" : "R2", i),
                     32'(tap_data[i*DW +: DW]), 32'(hist[n_acc-1-OFFS[i]]));
               last_exp[i] = hist[n_acc-1-OFFS[i]];
               known[i] = 1'b1;
            end else begin
               known[i] = 1'b0;
            end
         end else if (known[i]) begin
            check($sformatf("%s/R6 tap%0d hold", tag, i),
                  32'(tap_data[i*DW +: DW]), 32'(last_exp[i]));
         end
      end
   endtask

   task automatic t_reset();
      for (int i = 0; i < NT; i++) known[i] = 1'b0;
      check("R7 valid low after reset", 32'(tap_valid), 32'd0);
   endtask

   task automatic t_stream();
      for (int k = 0; k < 400; k++) step(1'b1, DW'(16'h1000 + k), "R4");
   endtask

   task automatic t_gaps();
      for (int k = 0; k < 300; k++) begin
         bit v;
         v = (k % 3) != 1;
         step(v, DW'($urandom), "R6");
      end
      for (int k = 0; k < 5; k++) step(1'b0, DW'($urandom), "R6");
   endtask

   task automatic t_wrap();
      for (int k = 0; k < DEPTH + 150; k++) step(1'b1, DW'(16'h8000 ^ (k * 7)), "R1");
   endtask

   task automatic t_midreset();
      in_valid = 1'b1;
      in_data  = 16'hdead;
      rst      = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rst   = 1'b0;
      n_acc = 0;
      for (int i = 0; i < NT; i++) known[i] = 1'b0;
      check("R7 valid cleared by mid-stream reset", 32'(tap_valid), 32'd0);
      for (int k = 0; k < 360; k++) step(1'b1, DW'(16'h4000 + k), "R7");
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL R4 watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_stream();
      t_gaps();
      t_wrap();
      t_midreset();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule